// File: doc/BRIEF.md
# FIFO-Buffered Asynchronous Serial Port

This block is an asynchronous serial port that sits on a simple 16-bit register bus. Software queues bytes into a 16-entry transmit FIFO and pulls received bytes out of a 16-entry receive FIFO. Each frame is one start bit, eight data bits sent least significant bit first, and one stop bit. No parity bit is used. An 8-bit divider N sets the bit period to 32×(N+1) system clocks. A control register enables the transmitter and the receiver separately. A FIFO control register can hold either FIFO empty.

The bus is synchronous. A write takes effect on the clock edge at which `bus_we` is high. Read data is combinational from `bus_addr`. Reading the receive data offset with `bus_re` high pops one byte at that edge. Status flags that report events are sticky. Software clears one by writing 0 to its bit, so a masked read-modify-write affects only the bit it targets.

Top module: `fifo_uart`

## Requirements
- R1: After a synchronous active-low reset, status (offset 0x10) reads 0x0040, the FIFO count (0x1C), line status (0x24), control (0x08) and divider (0x04) registers read 0, and `txd` is 1.
- R2: The transmitter drives a low start bit for exactly 32×(N+1) clocks, where N is the divider at offset 0x04. It then sends the 8 data bits, least significant first, each for the same time, and then a high stop bit.
- R3: Control bit 5 enables the transmitter and bit 4 enables the receiver. While bit 5 is 0, queued bytes stay in the FIFO and `txd` stays 1. While bit 4 is 0, frames on `rxd` are not stored.
- R4: A write to offset 0x0C queues a byte in the 16-entry transmit FIFO. A write when the FIFO is full is dropped. The transmit fill count reads at FIFO count bits 12:8.
- R5: A frame received on `rxd` is stored in the receive FIFO and sets status bit 0 (data ready). The receive fill count reads at FIFO count bits 4:0. Reading offset 0x14 returns the oldest byte and pops it.
- R6: Reading offset 0x14 with the receive FIFO empty returns the byte that was last popped.
- R7: A byte that arrives while the receive FIFO holds 16 bytes is discarded and sets line status bit 0 (overrun). Status bit 1 sets when a stored byte brings the fill count to 8 or more.
- R8: A frame whose stop bit samples 0 is still stored and sets status bit 3 (framing) and bit 7 (receive error). If its data bits are also all 0, status bit 4 (break) sets as well.
- R9: A write to status clears each of bits 0, 1, 3, 4 and 7 where the written bit is 0. Writing 1 leaves that flag as it was.
- R10: Line status bit 0 clears only when a 0 is written to it.
- R11: FIFO control bit 1 empties the receive FIFO and bit 2 empties the transmit FIFO. Each FIFO stays empty, dropping new bytes, until its bit is written back to 0.
- R12: Status bit 6 (transmit end) is 1 exactly when the transmit FIFO is empty and no frame is being shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (pops receive data at offset 0x14) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |

## Verification
The bench fills each FIFO past its depth. A design with an off-by-one limit would keep a 17th byte or fail to raise overrun. It sends frames with a low stop bit, and an all-zero frame, to confirm that the byte is kept and the right error flags rise. A receiver that dropped the byte or confused break with framing would fail here. It writes all-ones and single-bit-masked values to status, which catches flags that clear on a write of 1 or clear as a group. It measures the start-bit length at a nonzero divider, which exposes a wrong multiplier, and it checks that flush, transmit enable and receive enable each hold their FIFO as stated.

// File: rtl/uart_pkg.sv
// Package: register offsets, bit positions and the receive result type shared
// by the serial port modules. Assumes byte offsets on an 8-bit address.
package uart_pkg;
    localparam logic [7:0] OFS_MODE = 8'h00;
    localparam logic [7:0] OFS_BRR  = 8'h04;
    localparam logic [7:0] OFS_CTRL = 8'h08;
    localparam logic [7:0] OFS_TDR  = 8'h0C;
    localparam logic [7:0] OFS_STAT = 8'h10;
    localparam logic [7:0] OFS_RDR  = 8'h14;
    localparam logic [7:0] OFS_FCTL = 8'h18;
    localparam logic [7:0] OFS_FCNT = 8'h1C;
    localparam logic [7:0] OFS_LINE = 8'h24;

    localparam int ST_DR   = 0;
    localparam int ST_RFUL = 1;
    localparam int ST_FER  = 3;
    localparam int ST_BRK  = 4;
    localparam int ST_TEND = 6;
    localparam int ST_ER   = 7;

    localparam int CT_RE = 4;
    localparam int CT_TE = 5;

    localparam int FC_RFLUSH = 1;
    localparam int FC_TFLUSH = 2;

    localparam int LN_ORER = 0;

    typedef struct packed {
        logic [7:0] data;
        logic       ferr;
        logic       brk;
    } rx_frame_t;
endpackage

// File: rtl/uart_fifo.sv
// Module: synchronous FIFO with a level-held flush.
// Assumes DEPTH is a power of two. A push while full and a pop while empty are
// dropped. While flush is high the FIFO stays empty and ignores pushes.
module uart_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [WIDTH-1:0]           wdata,
    input  logic                       pop,
    output logic [WIDTH-1:0]           rdata,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = mem[rd_ptr];

    // Pointer and occupancy update, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // R4 / R7: a push into a full FIFO without a pop leaves it full, not wrapped
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (count == CW'(DEPTH)));

    // R11: flush leaves the FIFO empty on the next cycle
    a_r11_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/uart_tx.sv
// Module: transmit shifter. Sends start, 8 data bits LSB first, stop.
// Assumes div is stable during a frame. Each bit lasts 32*(div+1) clocks.
module uart_tx #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DIVW-1:0] div,
    input  logic            enable,
    input  logic            avail,
    input  logic [7:0]      data,
    output logic            take,
    output logic            txd,
    output logic            busy
);
    localparam int CNTW = DIVW + 5;

    logic [9:0]      sh_q;
    logic [3:0]      bit_q;
    logic [CNTW-1:0] cnt_q;
    logic [CNTW-1:0] per_last;
    logic            busy_q;
    logic            txd_q;

    assign per_last = {div, 5'h1F};
    assign take     = enable && avail && !busy_q;
    assign txd      = txd_q;
    assign busy     = busy_q;

    // Frame sequencer: load on take, shift one bit per period, stop after bit 9.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '1;
            bit_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            txd_q  <= 1'b1;
        end else if (take) begin
            sh_q   <= {1'b1, data, 1'b0};
            bit_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b1;
            txd_q  <= 1'b0;
        end else if (busy_q) begin
            if (cnt_q == per_last) begin
                cnt_q <= '0;
                if (bit_q == 4'd9) begin
                    busy_q <= 1'b0;
                    txd_q  <= 1'b1;
                end else begin
                    bit_q <= bit_q + 1'b1;
                    sh_q  <= {1'b1, sh_q[9:1]};
                    txd_q <= sh_q[1];
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R2: a loaded frame begins with a low start bit
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !txd);

    // R2: the line only changes at a bit boundary
    a_r2_bit_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0) |-> $stable(txd_q));
endmodule

// File: rtl/uart_rx.sv
// Module: receive shifter. Detects a falling edge, checks the start bit at
// half a period, samples each bit mid-period, reports one frame per stop bit.
// Assumes rxd is asynchronous; it is passed through two flops first.
module uart_rx #(
    parameter int DIVW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIVW-1:0]     div,
    input  logic                enable,
    input  logic                rxd,
    output logic                valid,
    output uart_pkg::rx_frame_t frame
);
    localparam int CNTW = DIVW + 5;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

    rx_state_t       state_q;
    logic            s1_q, s2_q, prev_q;
    logic [CNTW-1:0] cnt_q;
    logic [2:0]      bit_q;
    logic [7:0]      sh_q;
    logic [CNTW-1:0] half_last;
    logic [CNTW-1:0] full_last;
    logic            fall;

    assign half_last = {1'b0, div, 4'hF};
    assign full_last = {div, 5'h1F};
    assign fall      = prev_q && !s2_q;

    // Line synchronizer and edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            s1_q   <= rxd;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    // Frame state machine with mid-bit sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            valid   <= 1'b0;
            frame   <= '0;
        end else begin
            valid <= 1'b0;
            case (state_q)
                RX_IDLE: begin
                    cnt_q <= '0;
                    if (enable && fall) state_q <= RX_START;
                end
                RX_START: begin
                    if (cnt_q == half_last) begin
                        cnt_q   <= '0;
                        bit_q   <= '0;
                        state_q <= s2_q ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt_q == full_last) begin
                        cnt_q <= '0;
                        sh_q  <= {s2_q, sh_q[7:1]};
                        if (bit_q == 3'd7) state_q <= RX_STOP;
                        else               bit_q   <= bit_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == full_last) begin
                        valid      <= 1'b1;
                        frame.data <= sh_q;
                        frame.ferr <= !s2_q;
                        frame.brk  <= !s2_q && (sh_q == 8'h00);
                        state_q    <= RX_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // R8: a break report always comes with a framing error
    a_r8_brk_has_fer: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && frame.brk) |-> frame.ferr);

    // R5: one report per frame, never on back-to-back cycles
    a_r5_single_report: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
endmodule

// File: rtl/fifo_uart.sv
// Module: top of the FIFO serial port. Decodes the register bus, holds the
// control and sticky flag state, and joins the FIFOs to the shifters.
// Assumes one bus access per cycle; read data is combinational.
module fifo_uart #(
    parameter int DIVW    = 8,
    parameter int DEPTH   = 16,
    parameter int RX_TRIG = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_we,
    input  logic        bus_re,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        rxd,
    output logic        txd
);
    import uart_pkg::*;

    localparam int CW = $clog2(DEPTH) + 1;

    logic [15:0]     mode_q;
    logic [DIVW-1:0] brr_q;
    logic            re_q, te_q;
    logic            rflush_q, tflush_q;
    logic            dr_q, rdf_q, fer_q, brk_q, er_q, orer_q;
    logic [7:0]      last_q;

    logic            st_wr, ln_wr, tdr_wr, rdr_rd;
    logic [7:0]      tx_head, rx_head;
    logic [CW-1:0]   tx_count, rx_count;
    logic            tx_full, tx_empty, rx_full, rx_empty;
    logic            tx_take, tx_busy, tend;
    logic            rx_valid;
    rx_frame_t       rx_frame;
    logic            rx_store, overrun_set, fer_set, brk_set, rdf_set;

    assign st_wr  = bus_we && (bus_addr == OFS_STAT);
    assign ln_wr  = bus_we && (bus_addr == OFS_LINE);
    assign tdr_wr = bus_we && (bus_addr == OFS_TDR);
    assign rdr_rd = bus_re && (bus_addr == OFS_RDR);

    assign rx_store    = rx_valid && !rflush_q && !rx_full;
    assign overrun_set = rx_valid && !rflush_q && rx_full;
    assign fer_set     = rx_valid && rx_frame.ferr;
    assign brk_set     = rx_valid && rx_frame.brk;
    assign rdf_set     = rx_store && (rx_count >= CW'(RX_TRIG - 1));
    assign tend        = tx_empty && !tx_busy;

    uart_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(tflush_q),
        .push(tdr_wr), .wdata(bus_wdata[7:0]), .pop(tx_take),
        .rdata(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    uart_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(rflush_q),
        .push(rx_valid), .wdata(rx_frame.data), .pop(rdr_rd),
        .rdata(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    uart_tx #(.DIVW(DIVW)) u_tx (
        .clk(clk), .rst_n(rst_n), .div(brr_q), .enable(te_q),
        .avail(!tx_empty), .data(tx_head), .take(tx_take),
        .txd(txd), .busy(tx_busy)
    );

    uart_rx #(.DIVW(DIVW)) u_rx (
        .clk(clk), .rst_n(rst_n), .div(brr_q), .enable(re_q),
        .rxd(rxd), .valid(rx_valid), .frame(rx_frame)
    );

    // Configuration registers: mode, divider, enables, flush holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            brr_q    <= '0;
            re_q     <= 1'b0;
            te_q     <= 1'b0;
            rflush_q <= 1'b0;
            tflush_q <= 1'b0;
        end else if (bus_we) begin
            case (bus_addr)
                OFS_MODE: mode_q <= bus_wdata;
                OFS_BRR:  brr_q  <= bus_wdata[DIVW-1:0];
                OFS_CTRL: begin
                    re_q <= bus_wdata[CT_RE];
                    te_q <= bus_wdata[CT_TE];
                end
                OFS_FCTL: begin
                    rflush_q <= bus_wdata[FC_RFLUSH];
                    tflush_q <= bus_wdata[FC_TFLUSH];
                end
                default: ;
            endcase
        end
    end

    // Sticky flags: set by events, cleared by a written 0; a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr_q   <= 1'b0;
            rdf_q  <= 1'b0;
            fer_q  <= 1'b0;
            brk_q  <= 1'b0;
            er_q   <= 1'b0;
            orer_q <= 1'b0;
        end else begin
            dr_q   <= (dr_q  & ~(st_wr & ~bus_wdata[ST_DR]))   | rx_store;
            rdf_q  <= (rdf_q & ~(st_wr & ~bus_wdata[ST_RFUL])) | rdf_set;
            fer_q  <= (fer_q & ~(st_wr & ~bus_wdata[ST_FER]))  | fer_set;
            brk_q  <= (brk_q & ~(st_wr & ~bus_wdata[ST_BRK]))  | brk_set;
            er_q   <= (er_q  & ~(st_wr & ~bus_wdata[ST_ER]))   | fer_set;
            orer_q <= (orer_q & ~(ln_wr & ~bus_wdata[LN_ORER])) | overrun_set;
        end
    end

    // Last popped receive byte, returned when the FIFO is read empty.
    always_ff @(posedge clk) begin
        if (!rst_n)                           last_q <= '0;
        else if (rdr_rd && !rx_empty && !rflush_q) last_q <= rx_head;
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_MODE: bus_rdata = mode_q;
            OFS_BRR:  bus_rdata[DIVW-1:0] = brr_q;
            OFS_CTRL: begin
                bus_rdata[CT_RE] = re_q;
                bus_rdata[CT_TE] = te_q;
            end
            OFS_STAT: begin
                bus_rdata[ST_DR]   = dr_q;
                bus_rdata[ST_RFUL] = rdf_q;
                bus_rdata[ST_FER]  = fer_q;
                bus_rdata[ST_BRK]  = brk_q;
                bus_rdata[ST_TEND] = tend;
                bus_rdata[ST_ER]   = er_q;
            end
            OFS_RDR:  bus_rdata[7:0] = rx_empty ? last_q : rx_head;
            OFS_FCTL: begin
                bus_rdata[FC_RFLUSH] = rflush_q;
                bus_rdata[FC_TFLUSH] = tflush_q;
            end
            OFS_FCNT: begin
                bus_rdata[CW-1:0]  = rx_count;
                bus_rdata[8 +: CW] = tx_count;
            end
            OFS_LINE: bus_rdata[LN_ORER] = orer_q;
            default:  bus_rdata = '0;
        endcase
    end

    // R9: a written 0 at the framing bit clears it unless a new error arrives
    a_r9_fer_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !bus_wdata[ST_FER] && !fer_set) |=> !fer_q);

    // R7: a byte arriving at a full receive FIFO raises overrun
    a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_set |=> orer_q);

    // R6: reading an empty receive FIFO keeps the returned byte unchanged
    a_r6_empty_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rdr_rd && rx_empty) |=> $stable(last_q));
endmodule

// File: tb/test_fifo_uart.sv
module test_fifo_uart;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rxd = 1'b1;
    logic        txd;

    int total = 0;
    int bad = 0;
    int per = 32;
    bit finished = 1'b0;

    fifo_uart i_fifo_uart (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input bit stop);
        @(negedge clk);
        rxd = 1'b0;
        repeat (per) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (per) @(negedge clk);
        end
        rxd = stop;
        repeat (per) @(negedge clk);
        rxd = 1'b1;
        repeat (per) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(8'h10, v); check("R1 status", v, 16'h0040);
        rd(8'h1C, v); check("R1 fifo count", v, 16'h0000);
        rd(8'h24, v); check("R1 line status", v, 16'h0000);
        rd(8'h08, v); check("R1 control", v, 16'h0000);
        rd(8'h04, v); check("R1 divider", v, 16'h0000);
        check("R1 txd idle", {15'b0, txd}, 16'h0001);
    endtask

    task automatic t_rx_basic;
        logic [15:0] v;
        wr(8'h08, 16'h0010);
        wr(8'h10, 16'h0000);
        send(8'hA5, 1'b1);
        send(8'h3C, 1'b1);
        rd(8'h1C, v); check("R5 rx count", v & 16'h001F, 16'h0002);
        rd(8'h10, v); check("R5 data ready", v & 16'h0001, 16'h0001);
        rd(8'h14, v); check("R5 first byte", v & 16'h00FF, 16'h00A5);
        rd(8'h14, v); check("R5 second byte", v & 16'h00FF, 16'h003C);
        rd(8'h14, v); check("R6 empty read", v & 16'h00FF, 16'h003C);
        rd(8'h1C, v); check("R5 rx drained", v & 16'h001F, 16'h0000);
        wr(8'h08, 16'h0000);
        send(8'h77, 1'b1);
        rd(8'h1C, v); check("R3 receiver off", v & 16'h001F, 16'h0000);
        wr(8'h08, 16'h0010);
    endtask

    task automatic t_flag_clear;
        logic [15:0] v;
        wr(8'h10, 16'hFFFF);
        rd(8'h10, v); check("R9 write one keeps", v & 16'h0001, 16'h0001);
        wr(8'h10, 16'hFFFE);
        rd(8'h10, v); check("R9 write zero clears", v & 16'h0001, 16'h0000);
    endtask

    task automatic t_framing;
        logic [15:0] v;
        wr(8'h10, 16'h0000);
        send(8'h5A, 1'b0);
        rd(8'h10, v); check("R8 framing flags", v & 16'h009B, 16'h0089);
        rd(8'h14, v); check("R8 byte kept", v & 16'h00FF, 16'h005A);
        wr(8'h10, 16'h0000);
        send(8'h00, 1'b0);
        rd(8'h10, v); check("R8 break flags", v & 16'h009B, 16'h0099);
        wr(8'h10, 16'hFFEF);
        rd(8'h10, v); check("R9 single bit clear", v & 16'h009B, 16'h0089);
        rd(8'h14, v); check("R8 break byte", v & 16'h00FF, 16'h0000);
        wr(8'h10, 16'h0000);
    endtask

    task automatic t_overrun;
        logic [15:0] v;
        for (int i = 0; i < 17; i++) send(8'(i + 1), 1'b1);
        rd(8'h1C, v); check("R7 rx full count", v & 16'h001F, 16'h0010);
        rd(8'h10, v); check("R7 trigger flag", v & 16'h0002, 16'h0002);
        rd(8'h24, v); check("R7 overrun set", v & 16'h0001, 16'h0001);
        wr(8'h24, 16'h0001);
        rd(8'h24, v); check("R10 write one keeps", v & 16'h0001, 16'h0001);
        wr(8'h24, 16'h0000);
        rd(8'h24, v); check("R10 write zero clears", v & 16'h0001, 16'h0000);
        for (int i = 0; i < 15; i++) rd(8'h14, v);
        rd(8'h14, v); check("R7 last kept byte", v & 16'h00FF, 16'h0010);
        send(8'h11, 1'b1);
        wr(8'h18, 16'h0002);
        rd(8'h1C, v); check("R11 rx flushed", v & 16'h001F, 16'h0000);
        send(8'h22, 1'b1);
        rd(8'h1C, v); check("R11 rx held empty", v & 16'h001F, 16'h0000);
        wr(8'h18, 16'h0000);
        send(8'h42, 1'b1);
        rd(8'h14, v); check("R11 rx resumes", v & 16'h00FF, 16'h0042);
    endtask

    task automatic t_tx_hold;
        logic [15:0] v;
        int lows;
        wr(8'h08, 16'h0000);
        for (int i = 0; i < 17; i++) wr(8'h0C, 16'(i + 8'h30));
        lows = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!txd) lows++;
        end
        check("R3 transmitter off", 16'(lows), 16'h0000);
        rd(8'h1C, v); check("R4 tx count capped", v & 16'h1F00, 16'h1000);
        wr(8'h18, 16'h0004);
        rd(8'h1C, v); check("R11 tx flushed", v & 16'h1F00, 16'h0000);
        wr(8'h18, 16'h0000);
    endtask

    task automatic t_tx_frame;
        logic [15:0] v;
        logic [7:0] got;
        int low;
        wr(8'h04, 16'h0001);
        per = 64;
        wr(8'h0C, 16'h0055);
        wr(8'h08, 16'h0020);
        while (txd) @(negedge clk);
        low = 0;
        while (!txd) begin
            low++;
            @(negedge clk);
        end
        check("R2 start bit length", 16'(low), 16'd64);
        repeat (per / 2) @(negedge clk);
        got[0] = txd;
        for (int i = 1; i < 8; i++) begin
            repeat (per) @(negedge clk);
            got[i] = txd;
        end
        check("R2 data bits", {8'h00, got}, 16'h0055);
        repeat (per) @(negedge clk);
        check("R2 stop bit", {15'b0, txd}, 16'h0001);
        rd(8'h10, v); check("R12 tend while shifting", v & 16'h0040, 16'h0000);
        repeat (100) @(negedge clk);
        rd(8'h10, v); check("R12 tend when idle", v & 16'h0040, 16'h0040);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_basic();
        t_flag_clear();
        t_framing();
        t_overrun();
        t_tx_hold();
        t_tx_frame();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule